// File: doc/BRIEF.md
# Floating-Point Exception Status and Trap Unit

This block keeps the exception state of a floating-point unit and decides, after each completed operation, whether the operation must trap. The datapath reports a set of raw conditions with a valid strobe: a denormalized operand, an invalid operation, a zero divisor, an actual overflow, an actual underflow and a rounding loss. It also reports two hints: one that the operation could overflow, and one that the operation is the vector-transform instruction. A separate disable bit marks that the floating-point unit is switched off.

The unit holds a six-bit cause field that describes only the most recent operation, a five-bit sticky flag field, a five-bit trap enable field and a denormal-mode bit. Software writes any of these through a one-field-per-cycle write port. The unit produces two one-cycle requests: a floating-point exception request and an illegal-instruction request. The error source for denormal operands exists only in the cause field, and no enable can mask it. The invalid and overflow traps can fire on the instruction type or on a possible overflow, even when no actual event occurred.

Top module: `fpx_status_unit`

## Requirements
- R1: After reset, cause, flag, enable and the denormal-mode bit are all zero, and neither request is asserted.
- R2: On each accepted operation (op_valid=1, fpu_off=0), every cause bit is written. Cause bit [5] is the error source, [4] invalid, [3] divide-by-zero, [2] overflow, [1] underflow and [0] inexact. A bit is 1 when its source occurred and 0 when it did not.
- R3: The inexact source is active when an overflow, an underflow or a rounding loss occurred.
- R4: The error source is active when the denormal-mode bit is 0 and op_denorm_in is 1, and it always raises the exception request. When the denormal-mode bit is 1, this source is inactive.
- R5: When an accepted operation does not trap, each flag bit is ORed with the matching source. Flag and enable bit [4] is invalid, [3] divide-by-zero, [2] overflow, [1] underflow and [0] inexact. No flag bit is ever cleared by hardware.
- R6: An invalid trap is raised when enable[4]=1 and either an invalid operation occurred or op_vec_xform=1.
- R7: A trap is raised when enable[3]=1 and the divisor was zero. A trap is raised when enable[1]=1 and an underflow occurred. A trap is raised when enable[0]=1 and the inexact source is active.
- R8: An overflow trap is raised when enable[2]=1 and op_ovf_possible=1, whether or not an actual overflow occurred.
- R9: When an accepted operation traps, the cause field still updates and the flag field keeps its old value.
- R10: When op_valid=1 and fpu_off=1, illegal_req is raised, fpu_exc_req is not raised, and cause and flag keep their values.
- R11: Both requests are single-cycle pulses in the cycle after the operation. Neither request is asserted in a cycle that follows a cycle with op_valid=0.
- R12: A write with reg_wr_sel 0 loads cause from data[5:0], 1 loads flag from data[4:0], 2 loads enable from data[4:0], and 3 loads the denormal-mode bit from data[0]. The new value is visible in the next cycle, and a write overrides a hardware update of the same field in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | An operation completed this cycle |
| op_denorm_in | input | 1 | An operand was denormalized |
| op_invalid | input | 1 | Invalid operation, such as a NaN input |
| op_divzero | input | 1 | Division with a zero divisor |
| op_overflow | input | 1 | The result actually overflowed |
| op_underflow | input | 1 | The result actually underflowed |
| op_rounded | input | 1 | Rounding discarded nonzero bits |
| op_ovf_possible | input | 1 | The operation type could overflow |
| op_vec_xform | input | 1 | The operation is the vector-transform instruction |
| fpu_off | input | 1 | The floating-point unit is disabled |
| reg_wr_en | input | 1 | Software write strobe |
| reg_wr_sel | input | 2 | Field select: 0 cause, 1 flag, 2 enable, 3 mode |
| reg_wr_data | input | 6 | Write data |
| cause_o | output | 6 | Cause field |
| flag_o | output | 5 | Sticky flag field |
| enable_o | output | 5 | Trap enable field |
| denorm_mode_o | output | 1 | Denormal-mode bit |
| fpu_exc_req | output | 1 | Floating-point exception request pulse |
| illegal_req | output | 1 | Illegal-instruction request pulse |

## Verification
A software write and a hardware status update can land in the same cycle. The bench provokes this by asserting a write to cause, and separately a write to flag, in the same cycle as an accepted operation whose sources would set different bits. It then judges the next cycle's register value against the written data and not against the hardware result. The sweep also separates the two request functions: every operation pattern is repeated with fpu_off set, and the bench checks that only illegal_req fires and that cause and flag are left untouched.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
    localparam int CAUSE_W = 6;
    localparam int FLAG_W  = 5;
    localparam int SEL_W   = 2;

    localparam int B_ERR = 5;
    localparam int B_INV = 4;
    localparam int B_DVZ = 3;
    localparam int B_OVF = 2;
    localparam int B_UNF = 1;
    localparam int B_INX = 0;

    typedef enum logic [SEL_W-1:0] {
        SEL_CAUSE  = 2'd0,
        SEL_FLAG   = 2'd1,
        SEL_ENABLE = 2'd2,
        SEL_MODE   = 2'd3
    } fld_sel_e;

    typedef struct packed {
        logic [CAUSE_W-1:0] cause;
        logic [FLAG_W-1:0]  flag;
        logic [FLAG_W-1:0]  enable;
        logic               dn_mode;
        logic               exc_req;
        logic               ill_req;
    } fpx_state_t;
endpackage

// File: rtl/fpx_src_decode.sv
module fpx_src_decode
    import fpx_pkg::*;
(
    input  logic               denorm_in,
    input  logic               invalid,
    input  logic               divzero,
    input  logic               overflow,
    input  logic               underflow,
    input  logic               rounded,
    input  logic               dn_mode,
    output logic [CAUSE_W-1:0] src
);
    always_comb begin
        src        = '0;
        src[B_ERR] = denorm_in & ~dn_mode;
        src[B_INV] = invalid;
        src[B_DVZ] = divzero;
        src[B_OVF] = overflow;
        src[B_UNF] = underflow;
        src[B_INX] = overflow | underflow | rounded;
    end
endmodule

// File: rtl/fpx_trap_eval.sv
module fpx_trap_eval
    import fpx_pkg::*;
(
    input  logic [CAUSE_W-1:0] src,
    input  logic [FLAG_W-1:0]  enable,
    input  logic               vec_xform,
    input  logic               ovf_possible,
    output logic               trap
);
    logic [FLAG_W-1:0] armed;

    always_comb begin
        armed        = src[FLAG_W-1:0];
        armed[B_INV] = src[B_INV] | vec_xform;
        armed[B_OVF] = ovf_possible;
    end

    assign trap = src[B_ERR] | (|(armed & enable));
endmodule

// File: rtl/fpx_status_unit.sv
module fpx_status_unit
    import fpx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               op_valid,
    input  logic               op_denorm_in,
    input  logic               op_invalid,
    input  logic               op_divzero,
    input  logic               op_overflow,
    input  logic               op_underflow,
    input  logic               op_rounded,
    input  logic               op_ovf_possible,
    input  logic               op_vec_xform,
    input  logic               fpu_off,
    input  logic               reg_wr_en,
    input  logic [SEL_W-1:0]   reg_wr_sel,
    input  logic [CAUSE_W-1:0] reg_wr_data,
    output logic [CAUSE_W-1:0] cause_o,
    output logic [FLAG_W-1:0]  flag_o,
    output logic [FLAG_W-1:0]  enable_o,
    output logic               denorm_mode_o,
    output logic               fpu_exc_req,
    output logic               illegal_req
);
    fpx_state_t         st_q, st_d;
    logic [CAUSE_W-1:0] src;
    logic               trap;

    fpx_src_decode u_src (
        .denorm_in (op_denorm_in),
        .invalid   (op_invalid),
        .divzero   (op_divzero),
        .overflow  (op_overflow),
        .underflow (op_underflow),
        .rounded   (op_rounded),
        .dn_mode   (st_q.dn_mode),
        .src       (src)
    );

    fpx_trap_eval u_trap (
        .src          (src),
        .enable       (st_q.enable),
        .vec_xform    (op_vec_xform),
        .ovf_possible (op_ovf_possible),
        .trap         (trap)
    );

    always_comb begin
        st_d         = st_q;
        st_d.exc_req = 1'b0;
        st_d.ill_req = 1'b0;
        if (op_valid) begin
            if (fpu_off) begin
                st_d.ill_req = 1'b1;
            end else begin
                st_d.cause   = src;
                st_d.exc_req = trap;
                if (!trap) begin
                    st_d.flag = st_q.flag | src[FLAG_W-1:0];
                end
            end
        end
        if (reg_wr_en) begin
            case (fld_sel_e'(reg_wr_sel))
                SEL_CAUSE:  st_d.cause   = reg_wr_data;
                SEL_FLAG:   st_d.flag    = reg_wr_data[FLAG_W-1:0];
                SEL_ENABLE: st_d.enable  = reg_wr_data[FLAG_W-1:0];
                SEL_MODE:   st_d.dn_mode = reg_wr_data[0];
                default:    st_d.dn_mode = st_q.dn_mode;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cause_o       = st_q.cause;
    assign flag_o        = st_q.flag;
    assign enable_o      = st_q.enable;
    assign denorm_mode_o = st_q.dn_mode;
    assign fpu_exc_req   = st_q.exc_req;
    assign illegal_req   = st_q.ill_req;
endmodule

// File: rtl/fpx_status_unit_chk.sv
module fpx_status_unit_chk
    import fpx_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               op_valid,
    input logic               op_denorm_in,
    input logic               op_invalid,
    input logic               op_ovf_possible,
    input logic               fpu_off,
    input logic               reg_wr_en,
    input logic [CAUSE_W-1:0] cause_o,
    input logic [FLAG_W-1:0]  flag_o,
    input logic [FLAG_W-1:0]  enable_o,
    input logic               denorm_mode_o,
    input logic               fpu_exc_req,
    input logic               illegal_req
);
    a_r10_off_holds_state: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && fpu_off && !reg_wr_en) |=> ($stable(cause_o) && $stable(flag_o)));

    a_r10_requests_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(fpu_exc_req && illegal_req));

    a_r5_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr_en |=> ((flag_o & $past(flag_o)) == $past(flag_o)));

    a_r4_error_always_traps: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !fpu_off && op_denorm_in && !denorm_mode_o) |=> fpu_exc_req);

    a_r2_invalid_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !fpu_off && !reg_wr_en) |=> (cause_o[B_INV] == $past(op_invalid)));

    a_r8_possible_overflow_traps: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !fpu_off && op_ovf_possible && enable_o[B_OVF]) |=> fpu_exc_req);

    a_r11_no_request_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!fpu_exc_req && !illegal_req));
endmodule

bind fpx_status_unit fpx_status_unit_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .op_valid        (op_valid),
    .op_denorm_in    (op_denorm_in),
    .op_invalid      (op_invalid),
    .op_ovf_possible (op_ovf_possible),
    .fpu_off         (fpu_off),
    .reg_wr_en       (reg_wr_en),
    .cause_o         (cause_o),
    .flag_o          (flag_o),
    .enable_o        (enable_o),
    .denorm_mode_o   (denorm_mode_o),
    .fpu_exc_req     (fpu_exc_req),
    .illegal_req     (illegal_req)
);

// File: tb/fpx_status_unit_tb.sv
module fpx_status_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0, op_denorm_in = 1'b0, op_invalid = 1'b0, op_divzero = 1'b0;
    logic       op_overflow = 1'b0, op_underflow = 1'b0, op_rounded = 1'b0;
    logic       op_ovf_possible = 1'b0, op_vec_xform = 1'b0, fpu_off = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic [1:0] reg_wr_sel = 2'd0;
    logic [5:0] reg_wr_data = 6'd0;
    logic [5:0] cause_o;
    logic [4:0] flag_o, enable_o;
    logic       denorm_mode_o, fpu_exc_req, illegal_req;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    fpx_status_unit u_dut (.*);

    task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        op_valid = 1'b0; reg_wr_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [5:0] data);
        @(negedge clk);
        op_valid = 1'b0;
        reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = data;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic drive_op(input logic [8:0] v);
        {fpu_off, op_vec_xform, op_ovf_possible, op_rounded, op_underflow,
         op_overflow, op_divzero, op_invalid, op_denorm_in} = v;
        op_valid = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 cause", cause_o, 6'd0);
        chk("R1 flag", {1'b0, flag_o}, 6'd0);
        chk("R1 enable", {1'b0, enable_o}, 6'd0);
        chk("R1 mode/requests", {3'b0, denorm_mode_o, fpu_exc_req, illegal_req}, 6'd0);

        for (int dn = 0; dn < 2; dn++) begin
            for (int k = 0; k < 7; k++) begin
                logic [4:0] en;
                en = (k == 0) ? 5'h00 : (k == 6) ? 5'h1f : 5'(1 << (k - 1));
                for (int v = 0; v < 512; v++) begin
                    logic [4:0] fpre;
                    logic [5:0] cpre, src;
                    logic       inx, trap, off;
                    logic [4:0] f_exp;
                    logic [5:0] c_exp;
                    fpre = 5'(v ^ (k * 7) ^ dn);
                    cpre = 6'(v * 5 + k);
                    wr(2'd2, {1'b0, en});
                    wr(2'd3, 6'(dn));
                    wr(2'd0, cpre);
                    wr(2'd1, {1'b0, fpre});
                    chk("R11 idle no request", {4'b0, fpu_exc_req, illegal_req}, 6'd0);
                    chk("R12 enable write", {1'b0, enable_o}, {1'b0, en});
                    chk("R12 mode write", {5'b0, denorm_mode_o}, 6'(dn));
                    @(negedge clk);
                    drive_op(9'(v));
                    inx = op_overflow | op_underflow | op_rounded;
                    src = {op_denorm_in & (dn == 0), op_invalid, op_divzero,
                           op_overflow, op_underflow, inx};
                    trap = src[5] | (en[4] & (op_invalid | op_vec_xform)) |
                           (en[3] & op_divzero) | (en[2] & op_ovf_possible) |
                           (en[1] & op_underflow) | (en[0] & inx);
                    off = fpu_off;
                    c_exp = off ? cpre : src;
                    f_exp = (off || trap) ? fpre : (fpre | src[4:0]);
                    @(negedge clk);
                    op_valid = 1'b0;
                    chk("R2 R3 R4 R10 cause", cause_o, c_exp);
                    chk("R5 R9 R10 flag", {1'b0, flag_o}, {1'b0, f_exp});
                    chk("R4 R6 R7 R8 R10 exception request", {5'b0, fpu_exc_req}, {5'b0, ~off & trap});
                    chk("R10 illegal request", {5'b0, illegal_req}, {5'b0, off});
                end
            end
        end

        // R11 pulses last one cycle
        wr(2'd2, 6'h1f);
        wr(2'd3, 6'd0);
        @(negedge clk);
        drive_op(9'h001);
        @(negedge clk);
        op_valid = 1'b0;
        chk("R11 pulse high", {5'b0, fpu_exc_req}, 6'd1);
        @(negedge clk);
        chk("R11 pulse ends", {5'b0, fpu_exc_req}, 6'd0);

        // R12 write overrides same-cycle hardware update of cause
        wr(2'd2, 6'h00);
        wr(2'd1, 6'h00);
        @(negedge clk);
        drive_op(9'h00a);   // invalid + overflow, no trap
        reg_wr_en = 1'b1; reg_wr_sel = 2'd0; reg_wr_data = 6'h21;
        @(negedge clk);
        op_valid = 1'b0; reg_wr_en = 1'b0;
        chk("R12 cause write wins", cause_o, 6'h21);
        chk("R12 flag updated by hw", {1'b0, flag_o}, 6'h15);

        // R12 write overrides same-cycle hardware update of flag
        @(negedge clk);
        drive_op(9'h004);   // divide by zero, no trap
        reg_wr_en = 1'b1; reg_wr_sel = 2'd1; reg_wr_data = 6'h02;
        @(negedge clk);
        op_valid = 1'b0; reg_wr_en = 1'b0;
        chk("R12 flag write wins", {1'b0, flag_o}, 6'h02);
        chk("R12 cause updated by hw", cause_o, 6'h08);
        idle_cycle();
        chk("R11 idle after op", {4'b0, fpu_exc_req, illegal_req}, 6'd0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule